// File: doc/BRIEF.md
# BCD Calendar Clock with Memory-Mapped Register Window

This block keeps time of day and calendar date in BCD counters that advance once per second on a single-cycle `tick` pulse. The host never sees these counters directly. It reads and writes a register copy that sits in the top sixteen bytes of a byte-addressed window. The block refreshes that copy from the counters on the cycle after every tick. The calendar covers seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and a BCD century. It handles month lengths and leap years on its own.

A control byte in the window holds two flags and a five-bit calibration value. The calibration value is only stored and read back. The freeze flag stops the refresh so that the host can read a stable snapshot while the counters keep running. The edit flag opens the copy to host writes. Clearing the edit flag loads the edited copy into the counters.

A small sequencer orders these transfers. It has three states:
- `ST_IDLE` waits.
- `ST_COPY` is the refresh cycle after a tick. The refresh is skipped while either flag is set.
- `ST_LOAD` is the one-cycle transfer of the copy into the counters.

Its transitions are:
- IDLE→COPY on a tick.
- Any state→LOAD on a control write that clears a set edit flag.
- COPY→COPY on a back-to-back tick.
- LOAD→COPY when a tick coincides with the load.
- COPY/LOAD→IDLE otherwise.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the copy reads as second 00, minute 00, hour 00, day of week 01, date 01, month 01, year 00 and century RESET_CENTURY (20h by default), and the control byte reads 00h.
- R2: The window is the top 16 addresses (all upper address bits one). The low nibble selects the byte: F year, E month, D date, C day of week, B hour, A minute, 9 second, 1 century, 8 control. Read data appears on `rdata` one cycle after `rd_en` and holds while `rd_en` is low.
- R3: Each tick advances the counters by one second in BCD. Seconds and minutes wrap from 59 to 00 and carry into the next field. The copy shows the new time from the second cycle after the tick.
- R4: Hours count 00 to 23. Going from 23 to 00 steps the date, and steps the day of week, which wraps from 07 to 01.
- R5: Months 04, 06, 09 and 11 end after day 30. Month 02 ends after day 28 in common years. All other months end after day 31. The next day is day 01 of the following month, and month 12 wraps to 01.
- R6: A year whose BCD value is divisible by four is a leap year, and its February ends after day 29.
- R7: Year 99 wraps to 00 and steps the century. Century 99 wraps to 00.
- R8: While control bit 6 (freeze) is set, the copy does not change on ticks but the counters keep advancing. After the bit clears, the next tick shows the counters including every tick that occurred during the freeze.
- R9: Writes to clock bytes take effect only while control bit 7 (edit) is set, and while it is set the copy is not refreshed. A control write that clears a set edit bit loads the copy into the counters in one cycle, and following ticks count on from the loaded time.
- R10: Control bits 7, 6 and 4:0 read back as written, and bit 5 always reads 0.
- R11: A field holding a non-BCD or out-of-range value (including a date beyond its month's length) goes to its minimum on its next step and produces no carry.
- R12: Offsets 0 and 2 to 7 of the window, and every address below the window, read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| rd_en | input | 1 | Read strobe; `rdata` updates on the next cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with the default ADDR_W of 15 and a century reset value of 20h. The window therefore sits at 7FF0h–7FFFh, and an address such as 0FF9h shares the low nibble of a clock byte but lies outside the window. Because `tick` is an ordinary input pulsed every couple of cycles, the bench can preload the time just before a minute, day, month, year or century boundary and cross it within a few cycles. This brings every rollover path, the leap-year cases and the freeze and edit sequences within reach of short directed runs and seeded random ones.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    localparam int NUM_FIELDS     = 8;
    localparam int FIELD_W        = 8;
    localparam int CTL_EDIT_BIT   = 7;
    localparam int CTL_FREEZE_BIT = 6;
    localparam int CAL_WIDTH      = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_t;

    // second occupies slot 0 (LSB byte), century slot 7
    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } cal_time_t;

    function automatic logic bcd_ok(logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    // returns {carry, next value}
    function automatic logic [8:0] bcd_step(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
        if (!bcd_ok(v) || (v < lo) || (v > hi))
            return {1'b0, lo};
        else if (v == hi)
            return {1'b1, lo};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_year(logic [7:0] yr);
        if (yr[4])
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_days(logic [7:0] mon, logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // low address nibble -> {hit, slot}
    function automatic logic [3:0] slot_of(logic [3:0] off);
        case (off)
            4'h9:    return {1'b1, 3'd0};
            4'hA:    return {1'b1, 3'd1};
            4'hB:    return {1'b1, 3'd2};
            4'hC:    return {1'b1, 3'd3};
            4'hD:    return {1'b1, 3'd4};
            4'hE:    return {1'b1, 3'd5};
            4'hF:    return {1'b1, 3'd6};
            4'h1:    return {1'b1, 3'd7};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [7:0] field_reset(int idx, logic [7:0] cent);
        case (idx)
            3, 4, 5: return 8'h01;
            7:       return cent;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_next.sv
`timescale 1ns/1ps
module rtc_cal_next
    import rtc_cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);

    logic [8:0] s_sec, s_min, s_hour, s_wday, s_date, s_mon, s_year, s_cent;
    logic [7:0] date_max;

    always_comb begin
        date_max = month_days(cur.month, cur.year);
        s_sec    = bcd_step(cur.second, 8'h00, 8'h59);
        s_min    = bcd_step(cur.minute, 8'h00, 8'h59);
        s_hour   = bcd_step(cur.hour,   8'h00, 8'h23);
        s_wday   = bcd_step(cur.wday,   8'h01, 8'h07);
        s_date   = bcd_step(cur.date,   8'h01, date_max);
        s_mon    = bcd_step(cur.month,  8'h01, 8'h12);
        s_year   = bcd_step(cur.year,   8'h00, 8'h99);
        s_cent   = bcd_step(cur.cent,   8'h00, 8'h99);
    end

    always_comb begin
        nxt        = cur;
        nxt.second = s_sec[7:0];
        if (s_sec[8]) begin
            nxt.minute = s_min[7:0];
            if (s_min[8]) begin
                nxt.hour = s_hour[7:0];
                if (s_hour[8]) begin
                    nxt.wday = s_wday[7:0];
                    nxt.date = s_date[7:0];
                    if (s_date[8]) begin
                        nxt.month = s_mon[7:0];
                        if (s_mon[8]) begin
                            nxt.year = s_year[7:0];
                            if (s_year[8])
                                nxt.cent = s_cent[7:0];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_cal_regs.sv
`timescale 1ns/1ps
module rtc_cal_regs
    import rtc_cal_pkg::*;
#(
    parameter int         ADDR_W        = 15,
    parameter logic [7:0] RESET_CENTURY = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              refresh,
    input  cal_time_t         live,
    output cal_time_t         copy,
    output logic              freeze,
    output logic              edit,
    output logic              load_req
);

    localparam int         OFF_W   = 4;
    localparam int         CTL_PAD = FIELD_W - 2 - CAL_WIDTH;
    localparam logic [3:0] CTL_OFF = 4'h8;

    logic                          in_win;
    logic [OFF_W-1:0]              off;
    logic [3:0]                    slot_sel;
    logic                          ctl_hit;
    logic [7:0]                    ctl_q;
    logic [NUM_FIELDS*FIELD_W-1:0] copy_bits;
    logic [NUM_FIELDS*FIELD_W-1:0] live_bits;
    logic [7:0]                    rd_mux;

    assign in_win    = &addr[ADDR_W-1:OFF_W];
    assign off       = addr[OFF_W-1:0];
    assign slot_sel  = slot_of(off);
    assign ctl_hit   = wr_en && in_win && (off == CTL_OFF);
    assign live_bits = live;
    assign copy      = copy_bits;
    assign edit      = ctl_q[CTL_EDIT_BIT];
    assign freeze    = ctl_q[CTL_FREEZE_BIT];
    assign load_req  = ctl_hit && ctl_q[CTL_EDIT_BIT] && !wdata[CTL_EDIT_BIT];

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
            localparam logic [7:0] RST_V = field_reset(i, RESET_CENTURY);
            logic       host_hit;
            logic [7:0] slot_q;

            assign host_hit = wr_en && in_win && edit && slot_sel[3] && (slot_sel[2:0] == 3'(i));

            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q <= RST_V;
                else if (refresh)
                    slot_q <= live_bits[i*FIELD_W +: FIELD_W];
                else if (host_hit)
                    slot_q <= wdata;
            end

            assign copy_bits[i*FIELD_W +: FIELD_W] = slot_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= 8'h00;
        else if (ctl_hit)
            ctl_q <= {wdata[CTL_EDIT_BIT], wdata[CTL_FREEZE_BIT], {CTL_PAD{1'b0}}, wdata[CAL_WIDTH-1:0]};
    end

    always_comb begin
        if (!in_win)
            rd_mux = 8'h00;
        else if (off == CTL_OFF)
            rd_mux = ctl_q;
        else if (slot_sel[3])
            rd_mux = copy_bits[{slot_sel[2:0], 3'b000} +: FIELD_W];
        else
            rd_mux = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int         ADDR_W        = 15,
    parameter logic [7:0] RESET_CENTURY = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam cal_time_t CNT_RST = {RESET_CENTURY, 8'h00, 8'h01, 8'h01, 8'h01, 24'h000000};

    seq_state_t state_q, state_d;
    cal_time_t  cnt_q, step_in, step_out, copy_v;
    logic       freeze, edit, load_req, refresh;

    rtc_cal_regs #(
        .ADDR_W        (ADDR_W),
        .RESET_CENTURY (RESET_CENTURY)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .refresh  (refresh),
        .live     (cnt_q),
        .copy     (copy_v),
        .freeze   (freeze),
        .edit     (edit),
        .load_req (load_req)
    );

    rtc_cal_next u_next (
        .cur (step_in),
        .nxt (step_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_req)  state_d = ST_LOAD;
                else if (tick) state_d = ST_COPY;
            end
            ST_COPY: begin
                if (load_req)  state_d = ST_LOAD;
                else if (tick) state_d = ST_COPY;
                else           state_d = ST_IDLE;
            end
            ST_LOAD: begin
                if (tick) state_d = ST_COPY;
                else      state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        refresh = 1'b0;
        step_in = cnt_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_COPY: refresh = !freeze && !edit;
            ST_LOAD: step_in = copy_v;
            default: ;
        endcase
    end

    // live counters
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_RST;
        else if (state_q == ST_LOAD)
            cnt_q <= tick ? step_out : copy_v;
        else if (tick)
            cnt_q <= step_out;
    end

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       rd_en,
    input logic [7:0] rdata,
    input seq_state_t state,
    input cal_time_t  cnt,
    input cal_time_t  copy,
    input logic       freeze,
    input logic       edit,
    input logic       load_req
);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_tick_to_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && tick && !load_req |=> (state == ST_COPY));

    p_copy_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY) && !freeze && !edit |=> (copy == $past(cnt)));

    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !edit |=> $stable(copy));

    p_locked_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COPY) && !edit |=> $stable(copy));

    p_load_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) && !tick |=> (cnt == $past(copy)));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .state    (state_q),
    .cnt      (cnt_q),
    .copy     (copy_v),
    .freeze   (freeze),
    .edit     (edit),
    .load_req (load_req)
);

// File: tb/rtc_bcd_calendar_test.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_test;

    localparam int ADDR_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        wdata = 8'h00;
    wire  [7:0]        rdata;

    int checks = 0;
    int errors = 0;
    int mc, my, mmo, md, mw, mh, mmi, ms;

    always #2.5 clk = ~clk;

    rtc_bcd_calendar #(.ADDR_W(ADDR_W)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    function automatic logic [ADDR_W-1:0] at(logic [3:0] off);
        return {{(ADDR_W-4){1'b1}}, off};
    endfunction

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr_raw(logic [ADDR_W-1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] off, logic [7:0] d);
        wr_raw(at(off), d);
    endtask

    task automatic rd_raw(logic [ADDR_W-1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd(logic [3:0] off, output logic [7:0] v);
        rd_raw(at(off), v);
    endtask

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mmi++;
            if (mmi == 60) begin
                mmi = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mw = (mw == 7) ? 1 : mw + 1;
                    md++;
                    if (md > dim(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my++;
                            if (my == 100) begin
                                my = 0;
                                mc = (mc + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic ticks(int n, bit track);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
            if (track) model_step();
        end
    endtask

    task automatic set_time(int c, int y, int mo, int d, int w, int h, int mi, int s);
        mc = c; my = y; mmo = mo; md = d; mw = w; mh = h; mmi = mi; ms = s;
        wr(4'h8, 8'h80);
        wr(4'hF, bcd(y));
        wr(4'hE, bcd(mo));
        wr(4'hD, bcd(d));
        wr(4'hC, bcd(w));
        wr(4'hB, bcd(h));
        wr(4'hA, bcd(mi));
        wr(4'h9, bcd(s));
        wr(4'h1, bcd(c));
        wr(4'h8, 8'h00);
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [7:0] v;
        rd(4'h9, v); check({tag, " second"}, v, bcd(ms));
        rd(4'hA, v); check({tag, " minute"}, v, bcd(mmi));
        rd(4'hB, v); check({tag, " hour"},   v, bcd(mh));
        rd(4'hC, v); check({tag, " wday"},   v, bcd(mw));
        rd(4'hD, v); check({tag, " date"},   v, bcd(md));
        rd(4'hE, v); check({tag, " month"},  v, bcd(mmo));
        rd(4'hF, v); check({tag, " year"},   v, bcd(my));
        rd(4'h1, v); check({tag, " cent"},   v, bcd(mc));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        mc = 20; my = 0; mmo = 1; md = 1; mw = 1; mh = 0; mmi = 0; ms = 0;
        check_all("R1");
        rd(4'h8, v); check("R1 control", v, 8'h00);

        // R9 writes with edit clear are ignored
        wr(4'h9, 8'h33);
        rd(4'h9, v); check("R9 locked write", v, 8'h00);

        // R10 control readback
        wr(4'h8, 8'h3F);
        rd(4'h8, v); check("R10 bit5 masked", v, 8'h1F);
        wr(4'h8, 8'h5F);
        rd(4'h8, v); check("R10 flags+cal", v, 8'h5F);
        wr(4'h8, 8'h00);

        // R12 unmapped offsets and addresses outside the window
        wr(4'h8, 8'h80);
        wr(4'h2, 8'h77);
        rd(4'h2, v); check("R12 offset 2", v, 8'h00);
        rd(4'h0, v); check("R12 offset 0", v, 8'h00);
        wr_raw(15'h0FF9, 8'h44);
        rd_raw(15'h0FF9, v); check("R12 below window", v, 8'h00);
        rd(4'h9, v); check("R12 second untouched", v, 8'h00);
        wr(4'h8, 8'h00);
        @(negedge clk);

        // R2 read data holds without rd_en
        rd(4'h1, held);
        repeat (3) @(negedge clk);
        check("R2 rdata hold", rdata, held);

        // R3 BCD seconds/minutes
        set_time(20, 23, 6, 14, 3, 12, 34, 58);
        ticks(2, 1'b1);
        check_all("R3");
        set_time(20, 23, 6, 14, 3, 12, 59, 59);
        ticks(1, 1'b1);
        check_all("R3 hour carry");

        // R4 midnight, day of week wrap
        set_time(20, 23, 6, 15, 7, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R4");

        // R5 month lengths
        set_time(20, 23, 4, 30, 1, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R5 april");
        set_time(20, 23, 1, 31, 2, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R5 january");
        set_time(20, 23, 2, 28, 2, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R5 feb common");

        // R6 leap year
        set_time(20, 24, 2, 28, 3, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R6 feb 29");
        set_time(20, 24, 2, 29, 4, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R6 march 1");

        // R7 year and century wrap
        set_time(20, 99, 12, 31, 5, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R7 century step");
        set_time(99, 99, 12, 31, 6, 23, 59, 59);
        ticks(1, 1'b1);
        check_all("R7 century wrap");

        // R8 freeze
        set_time(20, 25, 3, 10, 1, 10, 20, 30);
        wr(4'h8, 8'h40);
        ticks(3, 1'b1);
        rd(4'h9, v); check("R8 frozen second", v, 8'h30);
        wr(4'h8, 8'h00);
        rd(4'h9, v); check("R8 no refresh before tick", v, 8'h30);
        ticks(1, 1'b1);
        check_all("R8 resumed");

        // R9 edit and load
        set_time(20, 25, 3, 11, 2, 8, 0, 0);
        wr(4'h8, 8'h80);
        ticks(2, 1'b0);
        rd(4'h9, v); check("R9 no refresh during edit", v, 8'h00);
        wr(4'h9, 8'h45);
        rd(4'h9, v); check("R9 edit write", v, 8'h45);
        wr(4'h8, 8'h00);
        @(negedge clk);
        ms = 45;
        ticks(1, 1'b1);
        check_all("R9 loaded");
        wr(4'h9, 8'h11);
        rd(4'h9, v); check("R9 locked again", v, 8'h46);

        // R11 invalid values
        set_time(20, 24, 4, 10, 2, 10, 15, 20);
        wr(4'h8, 8'h80);
        wr(4'h9, 8'h5A);
        wr(4'h8, 8'h00);
        @(negedge clk);
        ticks(1, 1'b0);
        rd(4'h9, v); check("R11 second to min", v, 8'h00);
        rd(4'hA, v); check("R11 no carry", v, 8'h15);
        set_time(20, 24, 4, 10, 2, 23, 59, 59);
        wr(4'h8, 8'h80);
        wr(4'hD, 8'h31);
        wr(4'h8, 8'h00);
        @(negedge clk);
        ticks(1, 1'b0);
        rd(4'hD, v); check("R11 date to 01", v, 8'h01);
        rd(4'hE, v); check("R11 month kept", v, 8'h04);
        rd(4'hB, v); check("R11 hour wrapped", v, 8'h00);

        // seeded random times near boundaries (R3 R4 R5 R6 R7)
        for (int it = 0; it < 40; it++) begin
            int c, y, mo, d, w, h, mi, s, n;
            c  = $urandom_range(99, 0);
            y  = ($urandom_range(3, 0) == 0) ? 99 : $urandom_range(99, 0);
            mo = ($urandom_range(3, 0) == 0) ? 12 : $urandom_range(12, 1);
            d  = $urandom_range(1, 0) ? dim(mo, y) : $urandom_range(dim(mo, y), 1);
            w  = $urandom_range(7, 1);
            h  = $urandom_range(1, 0) ? 23 : $urandom_range(23, 0);
            mi = $urandom_range(1, 0) ? 59 : $urandom_range(59, 0);
            s  = $urandom_range(1, 0) ? $urandom_range(59, 56) : $urandom_range(59, 0);
            n  = $urandom_range(4, 1);
            set_time(c, y, mo, d, w, h, mi, s);
            ticks(n, 1'b1);
            check_all("R3 R4 R5 R6 R7 random");
        end

        summary();
        $finish;
    end

endmodule